// File: doc/BRIEF.md
# ADC Calibration Mode Sequencer

This block is the digital controller that runs the four calibration routines of a sigma-delta converter. Software writes a 3-bit mode word. A code with its top bit set starts a calibration: zero-scale or full-scale, taken from an internal source or from the external input. From then on, each valid conversion result that the filter delivers counts as one output period. When the period count for the chosen routine is reached, the last result is stored in the offset or gain register of the selected channel. The mode word then falls back to idle.

While a calibration runs, the block drives several control outputs. It steers the input multiplexer to the internal short, the internal full-scale reference or the external pins. It forces the filter's fast-settling and skip options off, so the full filter path is used. It decides whether ac excitation stays on. A busy flag is high for the whole routine, and software can poll it. The calibration constants are held here, one offset and one gain word for each channel, and can be read through a combinational read port.

Top module: `adc_cal_sequencer`

## Requirements
- R1: A mode write while idle stores `mode_in` into `mode_q` on that edge. Codes 100 (internal zero-scale), 101 (internal full-scale), 110 (system zero-scale) and 111 (system full-scale) start a calibration and raise `busy` on the same edge.
- R2: With `chop_en`=1 sampled at start, a calibration ends on the 22nd valid result, or on the 44th valid result for internal full-scale.
- R3: With `chop_en`=0 sampled at start, a calibration ends on the 24th valid result, or on the 48th valid result for internal full-scale.
- R4: `busy` stays high from the start edge until the edge that accepts the final valid result, and falls on that edge.
- R5: On the completion edge `mode_q` returns to 000.
- R6: While `busy` is high, `filt_fast` and `filt_skip` are 0. While idle, they follow `fast_req` and `skip_req`.
- R7: A zero-scale calibration (100, 110) writes the offset register of the channel sampled at start. A full-scale calibration (101, 111) writes that channel's gain register. No other register changes.
- R8: Internal calibrations drive `ac_exc`=0. System calibrations drive `ac_exc` with the `ac_req` value sampled at start. While idle, `ac_exc` follows `ac_req`.
- R9: `src_sel` is 01 (internal short) during internal zero-scale, 10 (internal full-scale reference) during internal full-scale, and 00 (external input) during system calibrations and while idle.
- R10: The stored value is the `res_data` word that accompanied the final counted valid result.
- R11: Mode codes 000 to 011 start nothing. `busy` stays 0 and no calibration register changes, whatever results arrive.
- R12: A mode write that arrives while `busy` is high is ignored. It leaves `mode_q`, the period count, the target register and the channel unchanged.
- R13: After reset, `busy`=0, `mode_q`=000, every offset register is 0 and every gain register is 0x800000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_in | input | 3 | Mode code to write |
| chop_en | input | 1 | Chopping enabled, sampled at start |
| ac_req | input | 1 | ac excitation requested |
| fast_req | input | 1 | Fast filter option requested |
| skip_req | input | 1 | Skip filter option requested |
| chan_sel | input | 2 | Channel to calibrate, sampled at start |
| res_valid | input | 1 | Conversion result valid, one per output period |
| res_data | input | 24 | Conversion result |
| rd_chan | input | 2 | Channel shown on the read ports |
| mode_q | output | 3 | Current mode field |
| busy | output | 1 | Calibration in progress (ready flag) |
| src_sel | output | 2 | Input source: 00 external, 01 short, 10 full-scale ref |
| ac_exc | output | 1 | Effective ac excitation |
| filt_fast | output | 1 | Effective fast filter option |
| filt_skip | output | 1 | Effective skip filter option |
| offset_rd | output | 24 | Offset register of `rd_chan` |
| gain_rd | output | 24 | Gain register of `rd_chan` |

## Verification
The assertions assume that `res_valid` is a single-cycle pulse for each output period and that `rst_n` is applied before the first mode write. They also assume that `mode_in` is only meaningful while `mode_wr` is high. The stimulus drives each result pulse for exactly one clock, with random idle gaps between pulses. It changes the configuration inputs only together with a mode write, so that the values sampled at start are unambiguous. It also injects mode writes in the middle of a calibration on purpose, to show that they are dropped.

// File: rtl/adc_cal_sequencer.sv
module adc_cal_sequencer #(
  parameter int NCH     = 4,
  parameter int DW      = 24,
  parameter int CHOP_N  = 22,
  parameter int PLAIN_N = 24,
  parameter logic [DW-1:0] GAIN_RST = {1'b1, {(DW-1){1'b0}}},
  localparam int CHW = $clog2(NCH),
  localparam int CW  = $clog2(2*PLAIN_N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mode_wr,
  input  logic [2:0]     mode_in,
  input  logic           chop_en,
  input  logic           ac_req,
  input  logic           fast_req,
  input  logic           skip_req,
  input  logic [CHW-1:0] chan_sel,
  input  logic           res_valid,
  input  logic [DW-1:0]  res_data,
  input  logic [CHW-1:0] rd_chan,
  output logic [2:0]     mode_q,
  output logic           busy,
  output logic [1:0]     src_sel,
  output logic           ac_exc,
  output logic           filt_fast,
  output logic           filt_skip,
  output logic [DW-1:0]  offset_rd,
  output logic [DW-1:0]  gain_rd
);

  logic           chop_l, ac_l;
  logic [CHW-1:0] chan_l;
  logic [CW-1:0]  cnt;
  logic [DW-1:0]  off_r  [NCH];
  logic [DW-1:0]  gain_r [NCH];

  wire is_sys  = mode_q[1];
  wire is_full = mode_q[0];

  wire [CW-1:0] base   = chop_l ? CW'(CHOP_N) : CW'(PLAIN_N);
  wire [CW-1:0] target = (!is_sys && is_full) ? (base << 1) : base;
  wire          last   = busy && res_valid && (cnt == target - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 3'b000;
      busy   <= 1'b0;
      cnt    <= '0;
      chop_l <= 1'b0;
      ac_l   <= 1'b0;
      chan_l <= '0;
    end else if (!busy) begin
      if (mode_wr) begin
        mode_q <= mode_in;
        busy   <= mode_in[2];
        chop_l <= chop_en;
        ac_l   <= ac_req;
        chan_l <= chan_sel;
        cnt    <= '0;
      end
    end else if (res_valid) begin
      if (last) begin
        busy   <= 1'b0;
        mode_q <= 3'b000;
        cnt    <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        off_r[i]  <= '0;
        gain_r[i] <= GAIN_RST;
      end
    end else if (last) begin
      if (is_full) gain_r[chan_l] <= res_data;
      else         off_r[chan_l]  <= res_data;
    end
  end

  assign src_sel   = (!busy || is_sys) ? 2'b00 : (is_full ? 2'b10 : 2'b01);
  assign ac_exc    = busy ? (is_sys & ac_l) : ac_req;
  assign filt_fast = fast_req & ~busy;
  assign filt_skip = skip_req & ~busy;
  assign offset_rd = off_r[rd_chan];
  assign gain_rd   = gain_r[rd_chan];

endmodule

// File: rtl/adc_cal_sequencer_sva.sv
module adc_cal_sequencer_sva #(
  parameter int MAXP = 48
) (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_wr,
  input logic [2:0] mode_in,
  input logic       res_valid,
  input logic [2:0] mode_q,
  input logic       busy,
  input logic [1:0] src_sel,
  input logic       ac_exc,
  input logic       filt_fast,
  input logic       filt_skip
);

  logic [7:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seen <= '0;
    else if (!busy)            seen <= '0;
    else if (res_valid)        seen <= seen + 8'd1;
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode_wr && mode_in[2]) |=> (busy && mode_q == $past(mode_in)));

  p_len_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(seen) < MAXP));

  p_fall_on_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(res_valid));

  p_mode_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mode_q == 3'b000));

  p_full_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!filt_fast && !filt_skip));

  p_dc_internal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q[1]) |-> !ac_exc);

  p_src_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    src_sel != 2'b11);

  p_idle_noncal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && mode_wr && !mode_in[2]) |=> !busy);

  p_hold_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(mode_q));

endmodule

bind adc_cal_sequencer adc_cal_sequencer_sva #(.MAXP(2*PLAIN_N)) u_sva (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
  .res_valid(res_valid), .mode_q(mode_q), .busy(busy), .src_sel(src_sel),
  .ac_exc(ac_exc), .filt_fast(filt_fast), .filt_skip(filt_skip)
);

// File: tb/adc_cal_sequencer_test.sv
module adc_cal_sequencer_test;
  logic        clk = 0, rst_n = 0;
  logic        mode_wr = 0;
  logic [2:0]  mode_in = 0;
  logic        chop_en = 0, ac_req = 0, fast_req = 0, skip_req = 0;
  logic [1:0]  chan_sel = 0, rd_chan = 0;
  logic        res_valid = 0;
  logic [23:0] res_data = 0;
  logic [2:0]  mode_q;
  logic        busy, ac_exc, filt_fast, filt_skip;
  logic [1:0]  src_sel;
  logic [23:0] offset_rd, gain_rd;

  int tests = 0, fails = 0;
  logic [23:0] exp_off [4];
  logic [23:0] exp_gain[4];

  adc_cal_sequencer uut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int periods(input logic [2:0] m, input logic chop);
    int b = chop ? 22 : 24;
    return (m == 3'b101) ? 2*b : b;
  endfunction

  function automatic logic [1:0] exp_src(input logic [2:0] m);
    if (m[1]) return 2'b00;
    return m[0] ? 2'b10 : 2'b01;
  endfunction

  task automatic check_regs(input string req);
    bit ok = 1;
    for (int c = 0; c < 4; c++) begin
      rd_chan = 2'(c);
      #1;
      if (offset_rd !== exp_off[c] || gain_rd !== exp_gain[c]) ok = 0;
    end
    chk(ok, req, "calibration registers", offset_rd, exp_off[3]);
  endtask

  task automatic run_cal(input logic [2:0] m, input logic chop, input logic ac,
                         input logic [1:0] ch, input bit inj);
    int n = periods(m, chop);
    bit dur_ok = 1;
    logic [23:0] lastd = 0;
    @(negedge clk);
    mode_in = m; chop_en = chop; ac_req = ac; chan_sel = ch;
    fast_req = 1; skip_req = 1; mode_wr = 1;
    @(negedge clk);
    mode_wr = 0;
    chk(busy === 1 && mode_q === m, "R1", "start busy/mode", {busy, mode_q}, {1'b1, m});
    chk(filt_fast === 0 && filt_skip === 0, "R6", "filter forced off", {filt_fast, filt_skip}, 0);
    chk(ac_exc === (m[1] & ac), "R8", "excitation", ac_exc, m[1] & ac);
    chk(src_sel === exp_src(m), "R9", "source select", src_sel, exp_src(m));
    chop_en = ~chop; ac_req = ~ac; chan_sel = ~ch;
    for (int k = 1; k <= n; k++) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
      if (busy !== 1) dur_ok = 0;
      res_valid = 1;
      lastd = 24'($urandom);
      res_data = lastd;
      if (inj && k == 5) begin
        mode_wr = 1; mode_in = (m == 3'b101) ? 3'b100 : 3'b101;
      end
      @(negedge clk);
      res_valid = 0; mode_wr = 0;
      if (inj && k == 5)
        chk(mode_q === m && busy === 1, "R12", "mid-cal write ignored", mode_q, m);
      if (k < n && busy !== 1) dur_ok = 0;
    end
    chk(dur_ok && busy === 0, chop ? "R2" : "R3", "period count", busy, 0);
    chk(busy === 0, "R4", "busy falls after final result", busy, 0);
    chk(mode_q === 3'b000, "R5", "mode cleared", mode_q, 0);
    if (m[0]) exp_gain[ch] = lastd; else exp_off[ch] = lastd;
    check_regs("R7");
    rd_chan = ch; #1;
    chk((m[0] ? gain_rd : offset_rd) === lastd, "R10", "last result stored",
        m[0] ? gain_rd : offset_rd, lastd);
    fast_req = 0; skip_req = 1; ac_req = 1; #1;
    chk(filt_fast === 0 && filt_skip === 1 && ac_exc === 1 && src_sel === 2'b00,
        "R6", "idle passthrough", {filt_fast, filt_skip, ac_exc}, 3'b011);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int c = 0; c < 4; c++) begin exp_off[c] = 0; exp_gain[c] = 24'h800000; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy === 0 && mode_q === 0, "R13", "reset state", {busy, mode_q}, 0);
    check_regs("R13");

    for (int c = 0; c < 2; c++)
      for (int m = 4; m < 8; m++)
        run_cal(3'(m), 1'(c), 1'b1, 2'(m), 0);

    for (int m = 0; m < 4; m++) begin
      @(negedge clk);
      mode_in = 3'(m); mode_wr = 1;
      @(negedge clk);
      mode_wr = 0;
      for (int k = 0; k < 30; k++) begin
        res_valid = 1; res_data = 24'($urandom);
        @(negedge clk);
        res_valid = 0;
      end
      chk(busy === 0, "R11", "non-cal mode idle", busy, 0);
      check_regs("R11");
    end

    for (int i = 0; i < 12; i++)
      run_cal(3'($urandom_range(4, 7)), 1'($urandom), 1'($urandom),
              2'($urandom), (i % 3) == 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule